// File: doc/BRIEF.md
# Measurement Trigger and Interrupt Controller

This block decides when a measurement core converts and keeps the interrupt state that results produce. A conversion can start in three ways. Software can write a start strobe. An external event can start it on a rising edge, and that edge can be taken from the event as driven or from its inverse. Free-running mode starts a new conversion as soon as the previous one has finished. Starts are accepted only while the block is enabled and the core is idle. A start that arrives while the core is busy is dropped.

When the core finishes, the block records the result and raises the result-ready, overrun, window and overflow flags as they apply. Each flag has an interrupt enable bit. Software sets enable bits through one register and clears them through another. Flags are cleared by writing one to them. A single interrupt line combines the enabled flags.

Enabling, disabling and software reset each take effect after a short settling time. A busy register shows which of these is still pending. The measurement core is modelled here by a stub with a fixed latency. The window comparison is made outside the block and arrives as a single hit input.

Top module: `meas_seq_ctrl`

## Requirements
- R1: After `rst_n` is held low, every readable register returns 0 and `irq` is 0.
- R2: A write of 1 to bit 0 of the start register (address 1) starts one conversion when the block is enabled. The result-ready flag (flag bit 0) then sets, and the result register (address 9) returns the low `RES_W` bits of `sense_in` as captured at the start. While the block is disabled, the same write has no effect.
- R3: When event-start (bit 0 of the event register, address 3) is 1, a rising edge of `ev_in` XOR bit 1 of that register starts a conversion. When event-start is 0, the event input is ignored.
- R4: While the free-run bit (bit 4 of the mode register, address 2) is 1, conversions restart back to back. Once it is 0 and the last conversion has completed, no further results arrive.
- R5: A conversion that completes while result-ready is still set sets overrun (flag bit 1). Reading the result register clears result-ready.
- R6: When the most significant bit of the captured `sense_in` is 1, the completing conversion sets the overflow flag (flag bit 3). The status register (address 7) bit 0 then holds that overflow indication for the latest result.
- R7: A completing conversion with `win_hit_in` high sets the window flag (flag bit 2). It also gives a one-cycle `win_evt` pulse, but only when bit 2 of the event register is 1.
- R8: Writing 1 to a bit of the flag register (address 6) clears that flag. Writing 0 leaves it unchanged.
- R9: Writing 1 to a bit at address 5 sets that interrupt enable. Writing 1 at address 4 clears it. Reading either address returns the 4-bit enable mask, laid out like the flags.
- R10: `irq` is 1 exactly when some flag and its enable bit are both 1.
- R11: Control register (address 0) fields are: bit 0 software reset, bit 1 enable, bit 6 run-in-standby. A change of enable shows bit 1 of the busy register (address 8) for `SYNC_CYC` cycles before it takes effect. Software reset shows busy bit 0 for `SYNC_CYC` cycles and then returns every register to 0.
- R12: The core reports completion exactly `LAT` cycles after the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | RES_W | Read data, valid the cycle after the read strobe |
| ev_in | input | 1 | External start event |
| sense_in | input | RES_W+1 | Raw sample to the core; MSB marks overflow |
| win_hit_in | input | 1 | Window comparison hit for the current sample |
| irq | output | 1 | Interrupt line |
| win_evt | output | 1 | One-cycle window event pulse |

## Verification
A wrong start gate shows within one conversion latency: either a result-ready flag that should have stayed clear, or one that never arrives. A wrong flag update, such as a missed overrun, a W1C that clears too much, or a read that fails to clear result-ready, is visible in the next flag read and on `irq` in the same cycle. A broken settling counter shows in the busy register one cycle after the control write. It also shows as a software reset that leaves enables or flags standing once the busy bit drops.

// File: rtl/msc_pkg.sv
// Package: shared widths, register addresses and flag bit positions for the
// measurement trigger and interrupt controller.
// Assumes: a 4-bit word address and 8-bit write data on the register port.
package msc_pkg;
    localparam int ADDR_W = 4;
    localparam int WD_W   = 8;
    localparam int NFLAG  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_START  = 4'd1;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'd2;
    localparam logic [ADDR_W-1:0] A_EVCFG  = 4'd3;
    localparam logic [ADDR_W-1:0] A_IECLR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_IESET  = 4'd5;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd6;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd7;
    localparam logic [ADDR_W-1:0] A_BUSY   = 4'd8;
    localparam logic [ADDR_W-1:0] A_RESULT = 4'd9;

    localparam int F_RDY = 0;
    localparam int F_OVR = 1;
    localparam int F_WIN = 2;
    localparam int F_OVF = 3;

    localparam int C_SRST = 0;
    localparam int C_EN   = 1;
    localparam int C_STBY = 6;
    localparam int M_FREE = 4;
    localparam int E_EN   = 0;
    localparam int E_INV  = 1;
    localparam int E_WOUT = 2;
endpackage

// File: rtl/msc_sync_delay.sv
// Module: settling delay for a control change.
// A kick raises busy for CYC cycles; done pulses in the last busy cycle.
// Assumes: CYC >= 1; kicks while busy are ignored; clr aborts the wait.
module msc_sync_delay #(
    parameter int CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic clr,
    output logic busy,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign done = busy && (cnt_q == '0);

    // Count down the settling window after a kick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (kick) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CYC - 1);
        end
    end
endmodule

// File: rtl/msc_core_stub.sv
// Module: stand-in for the measurement core.
// It captures the sample on start and reports done LAT cycles later, with the
// low bits as the result and the top bit as the overflow indication.
// Assumes: start only arrives while idle; abort drops the conversion in flight.
module msc_core_stub #(
    parameter int RES_W = 24,
    parameter int LAT   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [RES_W:0]   sample,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             ovf
);
    localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int AW = $clog2(LAT + 2);

    logic [LW-1:0]  cnt_q;
    logic [RES_W:0] cap_q;
    logic [AW-1:0]  age_q;

    assign result = cap_q[RES_W-1:0];
    assign ovf    = cap_q[RES_W];

    // Run the fixed-latency conversion and pulse done at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (start) begin
                busy  <= 1'b1;
                cnt_q <= LW'(LAT - 1);
            end
        end
    end

    // Hold the sample taken at start.
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_q <= '0;
        else if (start && !busy) cap_q <= sample;
    end

    // Checker counter: cycles since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                age_q <= '0;
        else if (start && !busy)   age_q <= '0;
        else if (busy)             age_q <= age_q + 1'b1;
    end

    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age_q == AW'(LAT)));
endmodule

// File: rtl/msc_trigger.sv
// Module: merges the three start sources into a single start strobe.
// Sources: software one-shot, event edge (optionally inverted), free-run.
// Assumes: ev_in is synchronous to clk; starts while the core is busy,
// the block is disabled or a reset is settling are dropped.
module msc_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic en_eff,
    input  logic blocked,
    input  logic core_busy,
    input  logic oneshot,
    input  logic ev_en,
    input  logic ev_inv,
    input  logic ev_in,
    input  logic freerun,
    output logic start_go
);
    logic ev_lvl;
    logic ev_prev_q;
    logic ev_rise;
    logic gate;

    assign ev_lvl  = ev_in ^ ev_inv;
    assign ev_rise = ev_lvl && !ev_prev_q;
    assign gate    = en_eff && !blocked && !core_busy;

    // Remember the previous effective event level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_prev_q <= 1'b0;
        else        ev_prev_q <= ev_lvl;
    end

    // Combine sources behind the idle gate.
    always_comb begin
        start_go = gate && (oneshot || (ev_en && ev_rise) || freerun);
    end
endmodule

// File: rtl/msc_regs.sv
// Module: register file, flag logic and interrupt line.
// Holds control, mode, event, enable and flag state; applies the settled
// enable and the software reset clear; records each completed result.
// Assumes: reads return data one cycle after the strobe; a flag set by the
// core wins over a clear in the same cycle.
module msc_regs
    import msc_pkg::*;
#(
    parameter int RES_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WD_W-1:0]   bus_wdata,
    output logic [RES_W-1:0]  bus_rdata,
    input  logic              core_done,
    input  logic [RES_W-1:0]  core_res,
    input  logic              core_ovf,
    input  logic              win_hit,
    input  logic              srst_busy,
    input  logic              srst_done,
    input  logic              en_busy,
    input  logic              en_done,
    output logic              srst_kick,
    output logic              en_kick,
    output logic              en_eff,
    output logic              freerun,
    output logic              ev_en,
    output logic              ev_inv,
    output logic              oneshot,
    output logic              irq,
    output logic              win_evt
);
    logic             wr_ok;
    logic             rd_res;
    logic             ctrl_en_q;
    logic             ctrl_stby_q;
    logic             free_q;
    logic [2:0]       evcfg_q;
    logic [NFLAG-1:0] ien_q;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] flags_n;
    logic [NFLAG-1:0] w1c;
    logic [NFLAG-1:0] fset;
    logic [NFLAG-1:0] fclr;
    logic             stat_ovf_q;
    logic [RES_W-1:0] res_q;
    logic [WD_W-1:0]  small_rd;

    assign wr_ok     = bus_wr && !srst_busy;
    assign rd_res    = bus_rd && (bus_addr == A_RESULT);
    assign srst_kick = wr_ok && (bus_addr == A_CTRL) && bus_wdata[C_SRST];
    assign en_kick   = wr_ok && (bus_addr == A_CTRL) && !bus_wdata[C_SRST]
                       && (bus_wdata[C_EN] != ctrl_en_q) && !en_busy;
    assign oneshot   = wr_ok && (bus_addr == A_START) && bus_wdata[0];
    assign freerun   = free_q;
    assign ev_en     = evcfg_q[E_EN];
    assign ev_inv    = evcfg_q[E_INV];
    assign irq       = |(flags_q & ien_q);

    // Flag next state: core events set, W1C writes and result reads clear.
    always_comb begin
        w1c = (wr_ok && (bus_addr == A_FLAGS)) ? bus_wdata[NFLAG-1:0] : '0;
        fset = '0;
        fset[F_RDY] = core_done;
        fset[F_OVR] = core_done && flags_q[F_RDY] && !rd_res && !w1c[F_RDY];
        fset[F_WIN] = core_done && win_hit;
        fset[F_OVF] = core_done && core_ovf;
        fclr = w1c;
        fclr[F_RDY] = w1c[F_RDY] || rd_res;
        flags_n = (flags_q & ~fclr) | fset;
    end

    // Control, mode and event configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_done) begin
            ctrl_en_q   <= 1'b0;
            ctrl_stby_q <= 1'b0;
            free_q      <= 1'b0;
            evcfg_q     <= '0;
            en_eff      <= 1'b0;
        end else begin
            if (wr_ok && (bus_addr == A_CTRL) && !bus_wdata[C_SRST]) begin
                ctrl_stby_q <= bus_wdata[C_STBY];
                if (en_kick) ctrl_en_q <= bus_wdata[C_EN];
            end
            if (wr_ok && (bus_addr == A_MODE))  free_q  <= bus_wdata[M_FREE];
            if (wr_ok && (bus_addr == A_EVCFG)) evcfg_q <= bus_wdata[2:0];
            if (en_done) en_eff <= ctrl_en_q;
        end
    end

    // Interrupt enable mask: set and clear through separate addresses.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_done) begin
            ien_q <= '0;
        end else if (wr_ok && (bus_addr == A_IESET)) begin
            ien_q <= ien_q | bus_wdata[NFLAG-1:0];
        end else if (wr_ok && (bus_addr == A_IECLR)) begin
            ien_q <= ien_q & ~bus_wdata[NFLAG-1:0];
        end
    end

    // Flags, latest result, overflow status and window event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_done) begin
            flags_q    <= '0;
            res_q      <= '0;
            stat_ovf_q <= 1'b0;
            win_evt    <= 1'b0;
        end else begin
            flags_q <= flags_n;
            win_evt <= core_done && win_hit && evcfg_q[E_WOUT];
            if (core_done) begin
                res_q      <= core_res;
                stat_ovf_q <= core_ovf;
            end
        end
    end

    // Read mux for the byte-wide registers.
    always_comb begin
        small_rd = '0;
        case (bus_addr)
            A_CTRL: begin
                small_rd[C_SRST] = srst_busy;
                small_rd[C_EN]   = ctrl_en_q;
                small_rd[C_STBY] = ctrl_stby_q;
            end
            A_MODE:   small_rd[M_FREE]      = free_q;
            A_EVCFG:  small_rd[2:0]         = evcfg_q;
            A_IECLR,
            A_IESET:  small_rd[NFLAG-1:0]   = ien_q;
            A_FLAGS:  small_rd[NFLAG-1:0]   = flags_q;
            A_STATUS: small_rd[0]           = stat_ovf_q;
            A_BUSY:   small_rd[1:0]         = {en_busy, srst_busy};
            default:  small_rd = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr == A_RESULT) bus_rdata <= res_q;
            else                      bus_rdata <= RES_W'(small_rd);
        end
    end

    p_rdy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !srst_done) |=> flags_q[F_RDY]);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && flags_q[F_RDY] && !rd_res && !srst_done
         && !(wr_ok && (bus_addr == A_FLAGS) && bus_wdata[F_RDY]))
        |=> flags_q[F_OVR]);

    p_w1c_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && (bus_addr == A_FLAGS) && (bus_wdata[NFLAG-1:0] == '0)
         && !core_done && !rd_res && !srst_done)
        |=> (flags_q == $past(flags_q)));

    p_srst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> ((ien_q == '0) && (flags_q == '0) && !en_eff));
endmodule

// File: rtl/meas_seq_ctrl.sv
// Module: top of the measurement trigger and interrupt controller.
// Wires the register file, start-source merge, two settling delays and the
// measurement core stub together.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module meas_seq_ctrl
    import msc_pkg::*;
#(
    parameter int RES_W    = 24,
    parameter int LAT      = 4,
    parameter int SYNC_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [RES_W-1:0] reg_rdata,
    input  logic             ev_in,
    input  logic [RES_W:0]   sense_in,
    input  logic             win_hit_in,
    output logic             irq,
    output logic             win_evt
);
    logic srst_kick, srst_busy, srst_done;
    logic en_kick, en_busy, en_done;
    logic en_eff, freerun, ev_en, ev_inv, oneshot;
    logic start_go, core_busy, core_done, core_ovf;
    logic [RES_W-1:0] core_res;

    msc_regs #(.RES_W(RES_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(reg_wr), .bus_rd(reg_rd), .bus_addr(reg_addr),
        .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
        .core_done(core_done), .core_res(core_res), .core_ovf(core_ovf),
        .win_hit(win_hit_in),
        .srst_busy(srst_busy), .srst_done(srst_done),
        .en_busy(en_busy), .en_done(en_done),
        .srst_kick(srst_kick), .en_kick(en_kick), .en_eff(en_eff),
        .freerun(freerun), .ev_en(ev_en), .ev_inv(ev_inv),
        .oneshot(oneshot), .irq(irq), .win_evt(win_evt)
    );

    msc_sync_delay #(.CYC(SYNC_CYC)) u_srst_sync (
        .clk(clk), .rst_n(rst_n), .kick(srst_kick), .clr(1'b0),
        .busy(srst_busy), .done(srst_done)
    );

    msc_sync_delay #(.CYC(SYNC_CYC)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .kick(en_kick), .clr(srst_done),
        .busy(en_busy), .done(en_done)
    );

    msc_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .en_eff(en_eff), .blocked(srst_busy),
        .core_busy(core_busy), .oneshot(oneshot), .ev_en(ev_en),
        .ev_inv(ev_inv), .ev_in(ev_in), .freerun(freerun),
        .start_go(start_go)
    );

    msc_core_stub #(.RES_W(RES_W), .LAT(LAT)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start_go), .abort(srst_done),
        .sample(sense_in), .busy(core_busy), .done(core_done),
        .result(core_res), .ovf(core_ovf)
    );
endmodule

// File: tb/meas_seq_ctrl_tb.sv
module meas_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W = 24;

    typedef struct packed {
        logic [RES_W:0]   sense;
        logic             win;
        logic [RES_W-1:0] res;
        logic [3:0]       flg;
    } vec_t;

    localparam vec_t VEC [0:3] = '{
        '{25'h0000123, 1'b0, 24'h000123, 4'h1},
        '{25'h1000010, 1'b0, 24'h000010, 4'h9},
        '{25'h00ABCDE, 1'b1, 24'h0ABCDE, 4'h5},
        '{25'h1FFFFFF, 1'b1, 24'hFFFFFF, 4'hD}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [RES_W-1:0] reg_rdata;
    logic ev_in = 0;
    logic [RES_W:0] sense_in = 0;
    logic win_hit_in = 0;
    logic irq, win_evt;
    int checks = 0, errors = 0, win_cnt = 0;
    logic [RES_W-1:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    meas_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_in(ev_in), .sense_in(sense_in), .win_hit_in(win_hit_in),
        .irq(irq), .win_evt(win_evt)
    );

    always @(posedge clk) if (rst_n && win_evt) win_cnt <= win_cnt + 1;

    task automatic chk(input string req, input logic [RES_W-1:0] got,
                       input logic [RES_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [RES_W-1:0] v);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rdy(input string req);
        logic [RES_W-1:0] f;
        for (int i = 0; i < 40; i++) begin
            rd(4'd6, f);
            if (f[0]) return;
        end
        chk(req, 24'd0, 24'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], d);
            chk("R1 reset reg", d, 24'd0);
        end
        chk("R1 irq", {23'd0, irq}, 24'd0);

        // R2: start ignored while disabled
        wr(4'd1, 8'h01); idle(15);
        rd(4'd6, d); chk("R2 start while disabled", d, 24'd0);

        // R11: enable settles through busy bit 1
        wr(4'd0, 8'h42);
        rd(4'd8, d); chk("R11 enable busy", d, 24'd2);
        idle(5);
        rd(4'd8, d); chk("R11 busy drop", d, 24'd0);
        rd(4'd0, d); chk("R11 ctrl readback", d, 24'h42);

        // R2 R6 R7: vector table
        wr(4'd3, 8'h04);
        for (int i = 0; i < 4; i++) begin
            wr(4'd6, 8'h0F);
            sense_in = VEC[i].sense; win_hit_in = VEC[i].win;
            wr(4'd1, 8'h01);
            wait_rdy("R2 result ready");
            rd(4'd6, d); chk("R6 R7 flags", d, {20'd0, VEC[i].flg});
            rd(4'd7, d); chk("R6 status", d, {23'd0, VEC[i].flg[3]});
            rd(4'd9, d); chk("R2 result", d, VEC[i].res);
            rd(4'd6, d); chk("R5 read clears ready", d, {20'd0, VEC[i].flg & 4'hE});
        end
        chk("R7 win events", win_cnt[RES_W-1:0], 24'd2);
        win_hit_in = 0;

        // R7: no window event when output disabled
        wr(4'd3, 8'h00); wr(4'd6, 8'h0F);
        win_hit_in = 1; sense_in = 25'h11; wr(4'd1, 8'h01);
        wait_rdy("R7 run");
        chk("R7 event masked", win_cnt[RES_W-1:0], 24'd2);
        win_hit_in = 0;

        // R5: overrun on unread result
        wr(4'd6, 8'h0F); rd(4'd9, d);
        wr(4'd1, 8'h01); wait_rdy("R5 first");
        wr(4'd1, 8'h01); idle(12);
        rd(4'd6, d); chk("R5 overrun", d, 24'h3);

        // R8: write zero keeps, write one clears
        wr(4'd6, 8'h00);
        rd(4'd6, d); chk("R8 zero write", d, 24'h3);
        wr(4'd6, 8'h02);
        rd(4'd6, d); chk("R8 one clears", d, 24'h1);

        // R9: set/clear enable registers
        wr(4'd5, 8'h05);
        rd(4'd4, d); chk("R9 read clr addr", d, 24'h5);
        rd(4'd5, d); chk("R9 read set addr", d, 24'h5);
        wr(4'd4, 8'h01);
        rd(4'd5, d); chk("R9 after clear", d, 24'h4);

        // R10: irq follows enabled flags
        chk("R10 ready not enabled", {23'd0, irq}, 24'd0);
        wr(4'd6, 8'h0F); rd(4'd9, d);
        win_hit_in = 1; wr(4'd1, 8'h01); wait_rdy("R10 run");
        win_hit_in = 0;
        chk("R10 irq on window", {23'd0, irq}, 24'd1);
        wr(4'd6, 8'h04);
        chk("R10 irq drops", {23'd0, irq}, 24'd0);

        // R3: plain event start
        wr(4'd6, 8'h0F); rd(4'd9, d);
        wr(4'd3, 8'h01);
        @(negedge clk) ev_in = 1; @(negedge clk) ev_in = 0;
        wait_rdy("R3 event start");
        rd(4'd9, d);
        wr(4'd3, 8'h00); wr(4'd6, 8'h0F);
        @(negedge clk) ev_in = 1; @(negedge clk) ev_in = 0;
        idle(12);
        rd(4'd6, d); chk("R3 event ignored", d, 24'h0);
        // R3: inverted event
        ev_in = 1; wr(4'd3, 8'h03); idle(2); wr(4'd6, 8'h0F);
        @(negedge clk) ev_in = 0;
        wait_rdy("R3 inverted start");
        rd(4'd9, d); wr(4'd3, 8'h00);

        // R4: free-running
        sense_in = 25'h55; wr(4'd6, 8'h0F);
        wr(4'd2, 8'h10); idle(30);
        rd(4'd6, d); chk("R4 free-run overrun", d, 24'h3);
        wr(4'd2, 8'h00); idle(12);
        wr(4'd6, 8'h0F); idle(15);
        rd(4'd6, d); chk("R4 free-run stopped", d, 24'h0);

        // R11: software reset
        wr(4'd5, 8'h0F); wr(4'd3, 8'h07);
        wr(4'd0, 8'h01);
        rd(4'd8, d); chk("R11 reset busy", d, 24'h1);
        idle(6);
        rd(4'd0, d); chk("R11 ctrl cleared", d, 24'h0);
        rd(4'd5, d); chk("R11 enables cleared", d, 24'h0);
        rd(4'd3, d); chk("R11 event cfg cleared", d, 24'h0);
        rd(4'd8, d); chk("R11 busy clear", d, 24'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule